// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst, one address per clock. A start request loads a 9-bit starting column together with a burst-length code and a wrap-order select. From then on, each clock advances to the next beat in the selected order. Fixed-length bursts wrap inside an aligned block of 1, 2, 4 or 8 columns. The block can step through this block in sequential or interleaved order. Full-page bursts step through all 512 columns and keep going until they are stopped.

A terminate strobe ends a running burst early, as a burst-stop or precharge command would. A new start request is accepted in any cycle, including the middle of a burst, so the address stream can jump to a random column every cycle. The outputs come straight from registers. `valid_o` marks a cycle that carries a beat address, and `done_o` marks the end of a burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `valid_o` and `done_o` are 0 and `col_o` is 0.
- R2: If `start_i` is sampled high at a clock edge, then after that edge `valid_o` is 1 and `col_o` equals the sampled `start_col_i` (beat 0).
- R3: The `bl_code_i` values give the following burst lengths: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. Codes 3'b100, 3'b101 and 3'b110 behave as length 1.
- R4: With `wrap_il_i`=0 and fixed length BL=2^k, beat i outputs the start column with its low k bits replaced by (low k bits of start + i) mod BL. The upper 9-k bits stay unchanged.
- R5: With `wrap_il_i`=1 and fixed length BL=2^k, beat i outputs the start column with its low k bits XORed with i.
- R6: In full-page mode, beat i outputs (start + i) mod 512. `wrap_il_i` has no effect in this mode. `done_o` never rises on its own, and beats continue for as long as no terminate or start arrives.
- R7: For a fixed-length burst, `done_o` is 1 together with `valid_o` on the final beat (beat BL-1) and on no earlier beat.
- R8: If `term_i` is sampled high while a burst still has beats to come (and `start_i` is low), the next cycle shows `valid_o`=0 and `done_o`=1, and the cycle after that is idle. At any other time `term_i` is ignored.
- R9: `start_i` has priority. When it arrives during a burst, even together with `term_i`, the burst restarts from the new column with the new length and order.
- R10: In the cycle after the final beat of a fixed-length burst, with no new start, `valid_o` and `done_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a burst at `start_col_i` |
| start_col_i | input | 9 | Starting column |
| bl_code_i | input | 3 | Burst length code |
| wrap_il_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | The current cycle carries a beat |
| done_o | output | 1 | Final beat or terminated burst |

## Verification
The bench runs directed bursts of every length, in both orders, from start columns with nonzero low bits. Comparing the two orders from the same start column separates adding within the block from XORing within it. Start columns near the top of the block and near 511 show whether the upper bits are kept or a carry leaks into them. Full-page runs that cross column 511 check the modulo-512 wrap and show that the wrap select is ignored. Random traffic then mixes restarts, terminate strobes in busy and idle cycles, and the unused length codes. This tells apart priority between start and terminate, termination timing, and the fallback to length 1.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
    localparam int COL_W  = 9;
    localparam int CODE_W = 3;

    typedef logic [COL_W-1:0] col_t;

    typedef struct packed {
        col_t base;
        col_t idx;
        col_t mask;
        logic il;
        logic full;
        logic valid;
        logic done;
    } colgen_state_t;
endpackage

// File: rtl/sdram_bl_decode.sv
module sdram_bl_decode
    import sdram_colgen_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output col_t              mask_o,
    output logic              full_o
);
    always_comb begin
        full_o = 1'b0;
        case (code_i)
            3'b001:  mask_o = col_t'(1);
            3'b010:  mask_o = col_t'(3);
            3'b011:  mask_o = col_t'(7);
            3'b111: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default: mask_o = '0;
        endcase
    end
endmodule

// File: rtl/sdram_col_calc.sv
module sdram_col_calc
    import sdram_colgen_pkg::*;
(
    input  col_t base_i,
    input  col_t idx_i,
    input  col_t mask_i,
    input  logic il_i,
    output col_t col_o
);
    col_t sum;

    always_comb begin
        sum = base_i + idx_i;
        if (il_i) col_o = base_i ^ (idx_i & mask_i);
        else      col_o = (base_i & ~mask_i) | (sum & mask_i);
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              wrap_il_i,
    input  logic              term_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              done_o
);
    colgen_state_t st_d, st_q;
    col_t          dec_mask;
    logic          dec_full;
    col_t          idx_inc;
    logic          active;

    sdram_bl_decode u_dec (
        .code_i (bl_code_i),
        .mask_o (dec_mask),
        .full_o (dec_full)
    );

    sdram_col_calc u_calc (
        .base_i (st_q.base),
        .idx_i  (st_q.idx),
        .mask_i (st_q.mask),
        .il_i   (st_q.il),
        .col_o  (col_o)
    );

    assign idx_inc = st_q.idx + col_t'(1);
    assign active  = st_q.valid & ~st_q.done;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.base  = start_col_i;
            st_d.idx   = '0;
            st_d.mask  = dec_mask;
            st_d.full  = dec_full;
            st_d.il    = wrap_il_i & ~dec_full;
            st_d.valid = 1'b1;
            st_d.done  = ~dec_full & (dec_mask == '0);
        end else if (active) begin
            if (term_i) begin
                st_d.valid = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                st_d.idx   = idx_inc;
                st_d.valid = 1'b1;
                st_d.done  = ~st_q.full & (idx_inc == st_q.mask);
            end
        end else begin
            st_d.valid = 1'b0;
            st_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign done_o  = st_q.done;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk
    import sdram_colgen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic              term_i,
    input logic [COL_W-1:0]  col_o,
    input logic              valid_o,
    input logic              done_o
);
    // R2: a sampled start shows beat 0 at its column
    a_r2_start_beat0: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R8: done without a beat only follows an accepted terminate
    a_r8_term_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !valid_o) |-> $past(term_i));

    // R8: a terminate during an ongoing burst ends it in the next cycle
    a_r8_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !done_o && term_i && !start_i) |=> (!valid_o && done_o));

    // R6 R7: an ongoing burst keeps producing beats
    a_r7_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !done_o && !term_i && !start_i) |=> valid_o);

    // R10: done lasts one cycle unless restarted
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (!done_o && !valid_o));

    // R8: idle stays idle without start
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .done_o      (done_o)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       wrap_il_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // reference state
    int m_base, m_idx, m_len;
    bit m_il, m_valid, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .wrap_il_i(wrap_il_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .done_o(done_o)
    );

    function automatic int blen(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int idx, input int len, input bit il);
        int m;
        if (len == 0) return (base + idx) % 512;
        m = len - 1;
        if (il) return base ^ (idx & m);
        return (base & ~m & 511) | ((base + idx) & m);
    endfunction

    task automatic check(input string tag, input bit cond, input string what, input int act, input int expv);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic model_edge(input bit st, input int col, input logic [2:0] code, input bit il, input bit tm);
        if (st) begin
            m_base = col; m_idx = 0; m_len = blen(code);
            m_il = il && (m_len != 0);
            m_valid = 1; m_done = (m_len == 1);
        end else if (m_valid && !m_done) begin
            if (tm) begin
                m_valid = 0; m_done = 1;
            end else begin
                m_idx = (m_idx + 1) % 512;
                m_valid = 1;
                m_done = (m_len != 0) && (m_idx == m_len - 1);
            end
        end else begin
            m_valid = 0; m_done = 0;
        end
    endtask

    // drive at negedge, clock, compare at next negedge
    task automatic step(input string tag, input bit st, input int col, input logic [2:0] code,
                        input bit il, input bit tm);
        int ec;
        start_i = st; start_col_i = col[8:0]; bl_code_i = code; wrap_il_i = il; term_i = tm;
        @(posedge clk);
        model_edge(st, col, code, il, tm);
        @(negedge clk);
        check(tag, valid_o == m_valid, "valid_o", int'(valid_o), int'(m_valid));
        check(tag, done_o == m_done, "done_o", int'(done_o), int'(m_done));
        if (m_valid) begin
            ec = exp_col(m_base, m_idx, m_len, m_il);
            check(tag, int'(col_o) == ec, "col_o", int'(col_o), ec);
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 3'b000, 0, 0);
    endtask

    task automatic burst(input string tag, input int col, input logic [2:0] code, input bit il, input int beats);
        step(tag, 1, col, code, il, 0);
        for (int i = 1; i < beats; i++) step(tag, 0, 0, 3'b000, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_base = 0; m_idx = 0; m_len = 1; m_il = 0; m_valid = 0; m_done = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", valid_o == 0 && done_o == 0, "valid|done", int'(valid_o) + int'(done_o), 0);
        check("R1", col_o == 0, "col_o", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", valid_o == 0 && done_o == 0 && col_o == 0, "post-reset", int'(col_o), 0);

        // R2 R3 R7 R10: length 1
        burst("R2_R3_R7", 9'h0AB, 3'b000, 0, 1);
        idle("R10", 2);
        // R4: sequential lengths 2,4,8 from nonaligned starts
        burst("R4_R3", 9'h135, 3'b001, 0, 2);
        idle("R10", 1);
        burst("R4_R3", 9'h0F6, 3'b010, 0, 4);
        idle("R10", 1);
        burst("R4_R7", 9'h1FD, 3'b011, 0, 8);
        idle("R10", 2);
        // R5: interleaved
        burst("R5", 9'h0F6, 3'b010, 1, 4);
        idle("R10", 1);
        burst("R5_R7", 9'h1FD, 3'b011, 1, 8);
        idle("R10", 1);
        burst("R5", 9'h011, 3'b001, 1, 2);
        idle("R10", 1);
        // R3: unused codes behave as length 1
        burst("R3", 9'h055, 3'b100, 0, 1);
        idle("R3", 1);
        burst("R3", 9'h056, 3'b101, 1, 1);
        idle("R3", 1);
        burst("R3", 9'h057, 3'b110, 0, 1);
        idle("R3", 1);
        // R6: full page crossing 511, interleave ignored, never done
        burst("R6", 9'h1F0, 3'b111, 1, 40);
        step("R8", 0, 0, 3'b000, 0, 1);
        idle("R8", 2);
        burst("R6", 9'h000, 3'b111, 0, 600);
        step("R8", 0, 0, 3'b000, 0, 1);
        idle("R8", 1);
        // R8: term while idle ignored
        step("R8", 0, 0, 3'b000, 0, 1);
        step("R8", 0, 0, 3'b000, 0, 1);
        // R8: term mid fixed burst
        burst("R8", 9'h020, 3'b011, 0, 3);
        step("R8", 0, 0, 3'b000, 0, 1);
        step("R8", 0, 0, 3'b000, 0, 1);
        idle("R8", 1);
        // R9: restart mid burst, together with term
        burst("R9", 9'h100, 3'b011, 0, 3);
        step("R9", 1, 9'h0C3, 3'b010, 1, 1);
        idle("R9", 5);
        // R8: term on final beat cycle is ignored (burst already ending)
        burst("R8", 9'h040, 3'b001, 0, 2);
        step("R8", 0, 0, 3'b000, 0, 1);

        // random traffic
        void'($urandom(32'd1234));
        for (int i = 0; i < 6000; i++) begin
            int r;
            bit st, tm;
            logic [2:0] code;
            r = int'($urandom_range(0, 99));
            st = (r < 12);
            tm = ($urandom_range(0, 99) < 6);
            code = 3'($urandom_range(0, 7));
            step("R9_random", st, int'($urandom_range(0, 511)), code, 1'($urandom_range(0, 1)), tm);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule